// File: doc/BRIEF.md
# Video Sync Timing Generator

This block produces the line and field timing of a digital video decoder from its processing clock. A pixel counter measures out each line and a line counter measures out each field. The counters either run free or follow external active-low horizontal and vertical sync pins, passed through a synchronizer. From the counter state the block drives four outputs: a horizontal sync pulse, a vertical sync pulse, a reference output and a 3-bit field number. The reference output is either an active-video flag or a clamp pulse placed at a programmable point after the start of the line.

All timing values are plain input ports: line period, sync-to-burst, burst-to-video, active line count and clamp delay. Both the line period and the active line count arrive as a low byte plus a high part. The surrounding decoder owns the registers that hold these values.

Top module: `sync_timing_gen`

## Requirements
- R1: While reset is held low and directly after it, dhsync = 1, dvsync = 1 and field_id = 0. Both counters sit at zero, so in active mode dref = 0.
- R2: When external sync is selected, a falling edge on hsync_n restarts the line. The edge passes a two-flop synchronizer and an edge detector, so the pixel counter reads zero after the third rising clock edge that follows the pin change.
- R3: With no external edges, a line lasts P+1 clocks, where P = {line_len_hi, line_len_lo}. dhsync is high for the first 64 clocks of every line.
- R4: dvsync is high for exactly one whole line, line 0 of each field. Running free, a field lasts LINES_NTSC lines (pal_mode = 0) or LINES_PAL lines (pal_mode = 1).
- R5: The hsync_n and vsync_n pins have no effect unless sync_src_sel = 2'b00.
- R6: With pal_mode = 0, field_id steps by one at each field start and wraps from 3 to 0.
- R7: With pal_mode = 1, field_id steps by one at each field start and wraps from 7 to 0.
- R8: If hsync_n and vsync_n falling edges are detected in the same clock cycle, the line restarts as line 0 and field_id becomes 0 (field 1).
- R9: A vsync_n falling edge without a coincident hsync_n edge leaves the current line running. At the next line start the line counter goes to 0 and field_id advances.
- R10: When dref_sel = 0, dref = 1 exactly when both of these hold: the line number lies in [VBLANK_LINES, VBLANK_LINES + A), where A = {act_lines_hi, act_lines_lo}; and the pixel count is at least burst_ofs + video_ofs.
- R11: When dref_sel = 1, dref = 1 for pixel counts in [clamp_ofs, clamp_ofs + W). W = floor(CLK_KHZ * CLAMP_NS / 1e6), which is 13 clocks at the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hsync_n | input | 1 | External horizontal sync, active low |
| vsync_n | input | 1 | External vertical sync, active low |
| sync_src_sel | input | 2 | Sync source; 00 selects the external pins |
| pal_mode | input | 1 | 1 selects the 8-field sequence, 0 the 4-field sequence |
| line_len_lo | input | 8 | Line period, low byte |
| line_len_hi | input | PIX_W-8 | Line period, high bits |
| burst_ofs | input | 8 | Sync-to-burst offset in clocks |
| video_ofs | input | 8 | Burst-to-video offset in clocks |
| act_lines_lo | input | 8 | Active line count, low byte |
| act_lines_hi | input | LINE_W-8 | Active line count, high bits |
| dref_sel | input | 1 | 0 active-video flag, 1 clamp pulse |
| clamp_ofs | input | 8 | Clamp pulse delay from line start |
| dhsync | output | 1 | Horizontal sync output, active high |
| dvsync | output | 1 | Vertical sync output, active high |
| dref | output | 1 | Reference output (see R10, R11) |
| field_id | output | 3 | Field number minus one |

## Verification
Free-running lines of fixed length show the pulse widths, the line length and the field wrap in both standards. These results do not depend on the synchronizer. Directed edges on the sync pins isolate three things: the three-cycle restart latency, the different effects of coincident and lone vertical edges, and the masking of the pins under the other source selections. Random pulse trains then mix these cases with run-time changes of period, offsets and modes. A cycle model checks every output on every cycle, so an off-by-one in a window bound or a misplaced field step shows up as a mismatch on a specific cycle.

// File: rtl/sts_pkg.sv
package sts_pkg;
   localparam int FID_W = 3;
   typedef logic [FID_W-1:0] fid_t;
   typedef enum logic {DREF_ACTIVE = 1'b0, DREF_CLAMP = 1'b1} dref_mode_e;

   // next field number; 4-field sequence or 8-field sequence
   function automatic fid_t fid_advance(fid_t cur, logic pal);
      fid_t mask;
      mask = pal ? fid_t'(7) : fid_t'(3);
      return (cur + fid_t'(1)) & mask;
   endfunction
endpackage

// File: rtl/sts_edge_sync.sv
module sts_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic fall
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sts_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '1;
         prev_q <= 1'b1;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], pin_n};
         prev_q <= sh_q[STAGES-1];
      end
   end

   assign fall = prev_q & ~sh_q[STAGES-1];

   AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> !fall); // R2
endmodule

// File: rtl/sts_hcount.sv
module sts_hcount #(
   parameter int PIX_W    = 11,
   parameter int HS_WIDTH = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hs_fall,
   input  logic [PIX_W-1:0] period,
   output logic [PIX_W-1:0] pix,
   output logic             line_start,
   output logic             dhsync
);
   localparam logic [PIX_W:0] HS_LIM = HS_WIDTH[PIX_W:0];

   logic [PIX_W-1:0] pix_q;

   assign line_start = hs_fall | (pix_q >= period);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          pix_q <= '0;
      else if (line_start) pix_q <= '0;
      else                 pix_q <= pix_q + 1'b1;
   end

   assign pix    = pix_q;
   assign dhsync = ({1'b0, pix_q} < HS_LIM);

   AST_PIX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_q != '0) |-> (pix_q == $past(pix_q) + 1'b1)); // R3
endmodule

// File: rtl/sts_vcount.sv
module sts_vcount
   import sts_pkg::*;
#(
   parameter int LINE_W     = 10,
   parameter int LINES_NTSC = 262,
   parameter int LINES_PAL  = 312
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic              hs_fall,
   input  logic              vs_fall,
   input  logic              pal,
   output logic [LINE_W-1:0] line,
   output fid_t              field,
   output logic              dvsync
);
   localparam int LN1 = LINES_NTSC - 1;
   localparam int LP1 = LINES_PAL - 1;
   localparam logic [LINE_W-1:0] LAST_N = LN1[LINE_W-1:0];
   localparam logic [LINE_W-1:0] LAST_P = LP1[LINE_W-1:0];

   logic [LINE_W-1:0] line_q;
   fid_t              field_q;
   logic              pend_q;
   logic              coin;
   logic              at_last;
   logic              field_start;

   assign coin        = vs_fall & hs_fall;
   assign at_last     = line_q >= (pal ? LAST_P : LAST_N);
   assign field_start = line_start & (vs_fall | pend_q | at_last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q  <= '0;
         field_q <= '0;
         pend_q  <= 1'b0;
      end else begin
         if (line_start)   pend_q <= 1'b0;
         else if (vs_fall) pend_q <= 1'b1;
         if (field_start) begin
            line_q  <= '0;
            field_q <= coin ? fid_t'(0) : fid_advance(field_q, pal);
         end else if (line_start) begin
            line_q  <= line_q + 1'b1;
         end
      end
   end

   assign line   = line_q;
   assign field  = field_q;
   assign dvsync = (line_q == '0);

   AST_DVS_AT_LINE_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dvsync) |-> $past(line_start)); // R4
   AST_FIELD_AT_LINE0: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(field_q) |-> (line_q == '0)); // R6
   AST_COIN_FIELD1: assert property (@(posedge clk) disable iff (!rst_n)
      coin |=> (field_q == '0)); // R8
endmodule

// File: rtl/sts_dref.sv
module sts_dref
   import sts_pkg::*;
#(
   parameter int PIX_W        = 11,
   parameter int LINE_W       = 10,
   parameter int VBLANK_LINES = 20,
   parameter int CLAMP_CYC    = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PIX_W-1:0]  pix,
   input  logic [LINE_W-1:0] line,
   input  dref_mode_e        mode,
   input  logic [7:0]        burst_ofs,
   input  logic [7:0]        video_ofs,
   input  logic [LINE_W-1:0] act_lines,
   input  logic [7:0]        clamp_ofs,
   output logic              dref
);
   localparam logic [LINE_W:0] VSTART = VBLANK_LINES[LINE_W:0];
   localparam logic [PIX_W:0]  CL_W   = CLAMP_CYC[PIX_W:0];

   logic [8:0]       hstart9;
   logic [PIX_W:0]   hstart;
   logic [LINE_W:0]  vend;
   logic [PIX_W:0]   cl_lo;
   logic [PIX_W:0]   cl_hi;
   logic             act_on;
   logic             clamp_on;

   assign hstart9  = {1'b0, burst_ofs} + {1'b0, video_ofs};
   assign hstart   = {{(PIX_W-8){1'b0}}, hstart9};
   assign vend     = VSTART + {1'b0, act_lines};
   assign act_on   = ({1'b0, line} >= VSTART) && ({1'b0, line} < vend)
                     && ({1'b0, pix} >= hstart);
   assign cl_lo    = {{(PIX_W-7){1'b0}}, clamp_ofs};
   assign cl_hi    = cl_lo + CL_W;
   assign clamp_on = ({1'b0, pix} >= cl_lo) && ({1'b0, pix} < cl_hi);

   generate
      if (CLAMP_CYC > 1) begin : g_clamp_multi
         assign dref = (mode == DREF_CLAMP) ? clamp_on : act_on;
      end else begin : g_clamp_single
         assign dref = (mode == DREF_CLAMP) ? ({1'b0, pix} == cl_lo) : act_on;
      end
   endgenerate

   AST_CLAMP_START: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode == DREF_CLAMP) && $stable(mode) && $stable(clamp_ofs) && $rose(dref))
      |-> ({1'b0, pix} == cl_lo)); // R11
endmodule

// File: rtl/sync_timing_gen.sv
module sync_timing_gen
   import sts_pkg::*;
#(
   parameter int PIX_W        = 11,
   parameter int LINE_W       = 10,
   parameter int SYNC_STAGES  = 2,
   parameter int HS_WIDTH     = 64,
   parameter int LINES_NTSC   = 262,
   parameter int LINES_PAL    = 312,
   parameter int VBLANK_LINES = 20,
   parameter int CLK_KHZ      = 27000,
   parameter int CLAMP_NS     = 500
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hsync_n,
   input  logic              vsync_n,
   input  logic [1:0]        sync_src_sel,
   input  logic              pal_mode,
   input  logic [7:0]        line_len_lo,
   input  logic [PIX_W-9:0]  line_len_hi,
   input  logic [7:0]        burst_ofs,
   input  logic [7:0]        video_ofs,
   input  logic [7:0]        act_lines_lo,
   input  logic [LINE_W-9:0] act_lines_hi,
   input  logic              dref_sel,
   input  logic [7:0]        clamp_ofs,
   output logic              dhsync,
   output logic              dvsync,
   output logic              dref,
   output logic [2:0]        field_id
);
   localparam int CLAMP_CYC = (CLK_KHZ * CLAMP_NS) / 1000000;

   if (PIX_W < 9 || PIX_W > 16) begin : g_bad_pix
      $error("sync_timing_gen: PIX_W out of range");
   end
   if (LINE_W < 9 || LINES_PAL > (1 << LINE_W) || LINES_NTSC > (1 << LINE_W)) begin : g_bad_line
      $error("sync_timing_gen: LINE_W too small for field length");
   end
   if (CLAMP_CYC < 1) begin : g_bad_clamp
      $error("sync_timing_gen: clamp pulse shorter than one clock");
   end
   if (VBLANK_LINES >= LINES_NTSC || VBLANK_LINES >= LINES_PAL) begin : g_bad_vbl
      $error("sync_timing_gen: blanking longer than a field");
   end

   logic             ext_en;
   logic             hs_raw, vs_raw;
   logic             hs_fall, vs_fall;
   logic [PIX_W-1:0] pix;
   logic [LINE_W-1:0] line;
   logic             line_start;
   fid_t             field;

   assign ext_en = (sync_src_sel == 2'b00);

   sts_edge_sync #(.STAGES(SYNC_STAGES)) u_hs_sync (
      .clk(clk), .rst_n(rst_n), .pin_n(hsync_n), .fall(hs_raw));
   sts_edge_sync #(.STAGES(SYNC_STAGES)) u_vs_sync (
      .clk(clk), .rst_n(rst_n), .pin_n(vsync_n), .fall(vs_raw));

   assign hs_fall = ext_en & hs_raw;
   assign vs_fall = ext_en & vs_raw;

   sts_hcount #(.PIX_W(PIX_W), .HS_WIDTH(HS_WIDTH)) u_hcount (
      .clk(clk), .rst_n(rst_n), .hs_fall(hs_fall),
      .period({line_len_hi, line_len_lo}),
      .pix(pix), .line_start(line_start), .dhsync(dhsync));

   sts_vcount #(.LINE_W(LINE_W), .LINES_NTSC(LINES_NTSC), .LINES_PAL(LINES_PAL)) u_vcount (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .hs_fall(hs_fall),
      .vs_fall(vs_fall), .pal(pal_mode), .line(line), .field(field), .dvsync(dvsync));

   sts_dref #(.PIX_W(PIX_W), .LINE_W(LINE_W), .VBLANK_LINES(VBLANK_LINES),
              .CLAMP_CYC(CLAMP_CYC)) u_dref (
      .clk(clk), .rst_n(rst_n), .pix(pix), .line(line),
      .mode(dref_mode_e'(dref_sel)), .burst_ofs(burst_ofs), .video_ofs(video_ofs),
      .act_lines({act_lines_hi, act_lines_lo}), .clamp_ofs(clamp_ofs), .dref(dref));

   assign field_id = field;

   AST_PINS_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_en |-> !(hs_fall || vs_fall)); // R5
endmodule

// File: tb/sync_timing_gen_bench.sv
module sync_timing_gen_bench;
   localparam int LN = 12;
   localparam int LP = 15;
   localparam int VB = 3;
   localparam int CLW = 13;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hsync_n = 1'b1, vsync_n = 1'b1;
   logic [1:0] sync_src_sel = 2'b00;
   logic pal_mode = 1'b0;
   logic [7:0] line_len_lo = 8'd99;
   logic [2:0] line_len_hi = 3'd0;
   logic [7:0] burst_ofs = 8'd10, video_ofs = 8'd20;
   logic [7:0] act_lines_lo = 8'd7;
   logic [1:0] act_lines_hi = 2'd0;
   logic dref_sel = 1'b0;
   logic [7:0] clamp_ofs = 8'd30;
   logic dhsync, dvsync, dref;
   logic [2:0] field_id;

   int checks = 0, failures = 0;
   bit done = 0, cyc_on = 0;

   always #10 clk = ~clk;

   sync_timing_gen #(.LINES_NTSC(LN), .LINES_PAL(LP), .VBLANK_LINES(VB)) u_sync_timing_gen (
      .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
      .sync_src_sel(sync_src_sel), .pal_mode(pal_mode),
      .line_len_lo(line_len_lo), .line_len_hi(line_len_hi),
      .burst_ofs(burst_ofs), .video_ofs(video_ofs),
      .act_lines_lo(act_lines_lo), .act_lines_hi(act_lines_hi),
      .dref_sel(dref_sel), .clamp_ofs(clamp_ofs),
      .dhsync(dhsync), .dvsync(dvsync), .dref(dref), .field_id(field_id));

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // cycle model built from the requirements
   int m_pix, m_line, m_fld;
   bit m_pend, mh1, mh2, mhp, mv1, mv2, mvp;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_pix = 0; m_line = 0; m_fld = 0; m_pend = 0;
         mh1 = 1; mh2 = 1; mhp = 1; mv1 = 1; mv2 = 1; mvp = 1;
      end else begin
         bit ext, hf, vf, ls;
         int per, flines;
         ext = (sync_src_sel == 2'b00);
         hf = ext && mhp && !mh2;
         vf = ext && mvp && !mv2;
         per = {line_len_hi, line_len_lo};
         flines = pal_mode ? LP : LN;
         ls = hf || (m_pix >= per);
         if (ls) begin
            if (vf || m_pend || m_line >= flines - 1) begin
               m_line = 0;
               m_fld = (hf && vf) ? 0 : ((m_fld + 1) & (pal_mode ? 7 : 3));
            end else m_line++;
            m_pend = 0; m_pix = 0;
         end else begin
            if (vf) m_pend = 1;
            m_pix++;
         end
         mhp = mh2; mh2 = mh1; mh1 = hsync_n;
         mvp = mv2; mv2 = mv1; mv1 = vsync_n;
      end
   end

   function automatic int exp_dref();
      int hs, al;
      hs = burst_ofs + video_ofs;
      al = {act_lines_hi, act_lines_lo};
      if (dref_sel) return int'(m_pix >= clamp_ofs && m_pix < clamp_ofs + CLW);
      return int'(m_line >= VB && m_line < VB + al && m_pix >= hs);
   endfunction

   always @(negedge clk) begin
      if (rst_n && cyc_on) begin
         chk("R3 dhsync", int'(dhsync), int'(m_pix < 64));
         chk("R4 dvsync", int'(dvsync), int'(m_line == 0));
         chk(pal_mode ? "R7 field_id" : "R6 field_id", int'(field_id), m_fld);
         chk(dref_sel ? "R11 dref" : "R10 dref", int'(dref), exp_dref());
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic wait_dh_rise();
      logic p;
      p = dhsync;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (dhsync && !p) return;
         p = dhsync;
      end
   endtask

   task automatic wait_field(int f);
      for (int i = 0; i < 40000; i++) begin
         @(negedge clk);
         if (field_id == f) return;
      end
   endtask

   task automatic pulse(bit h, bit v, int w);
      @(negedge clk);
      if (h) hsync_n = 1'b0;
      if (v) vsync_n = 1'b0;
      repeat (w) @(negedge clk);
      hsync_n = 1'b1; vsync_n = 1'b1;
   endtask

   initial begin
      int n, len, f0;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk("R1 dhsync", int'(dhsync), 1);
      chk("R1 dvsync", int'(dvsync), 1);
      chk("R1 field_id", int'(field_id), 0);
      chk("R1 dref", int'(dref), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 field_id after release", int'(field_id), 0);
      cyc_on = 1;

      // free-running timing, 4-field standard
      sync_src_sel = 2'b01;
      wait_dh_rise();
      n = 0; len = 0;
      while (dhsync) begin n++; len++; @(negedge clk); end
      while (!dhsync) begin len++; @(negedge clk); end
      chk("R3 dhsync width", n, 64);
      chk("R3 line length", len, 100);
      wait_field(3);
      wait_field(0);
      chk("R6 wrap 3 to 0", int'(field_id), 0);
      n = 0; len = 0;
      while (dvsync) begin n++; len++; @(negedge clk); end
      while (!dvsync) begin len++; @(negedge clk); end
      chk("R4 dvsync width", n, 100);
      chk("R4 field length", len, LN * 100);

      // clamp pulse placement
      dref_sel = 1'b1;
      wait_dh_rise();
      n = 0;
      while (!dref && n < 500) begin n++; @(negedge clk); end
      chk("R11 clamp start", n, 30);
      len = 0;
      while (dref && len < 500) begin len++; @(negedge clk); end
      chk("R11 clamp width", len, CLW);
      dref_sel = 1'b0;

      // 8-field standard
      pal_mode = 1'b1;
      wait_field(7);
      wait_field(0);
      chk("R7 wrap 7 to 0", int'(field_id), 0);
      pal_mode = 1'b0;
      wait_field(1);

      // pins ignored when another source is selected
      line_len_hi = 3'd7; line_len_lo = 8'd208; // period 2000
      wait_dh_rise();
      repeat (100) @(negedge clk);
      f0 = field_id;
      pulse(1, 1, 4);
      repeat (4) @(negedge clk);
      chk("R5 dhsync unaffected", int'(dhsync), 0);
      chk("R5 field unaffected", int'(field_id), f0);

      // external sync: restart latency
      sync_src_sel = 2'b00;
      repeat (100) @(negedge clk);
      @(negedge clk); hsync_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R2 no restart yet", int'(dhsync), 0);
      @(negedge clk);
      chk("R2 restart after 3 edges", int'(dhsync), 1);
      hsync_n = 1'b1;

      // coincidence then lone vertical edges
      repeat (100) @(negedge clk);
      pulse(1, 1, 4);
      repeat (2) @(negedge clk);
      chk("R8 field 1 on coincidence", int'(field_id), 0);
      chk("R8 line 0 on coincidence", int'(dvsync), 1);
      for (int k = 1; k <= 2; k++) begin
         repeat (100) @(negedge clk);
         pulse(1, 0, 3);
         repeat (100) @(negedge clk);
         pulse(0, 1, 3);
         repeat (4) @(negedge clk);
         chk("R9 line kept after lone vsync", int'(dvsync), 0);
         pulse(1, 0, 3);
         repeat (2) @(negedge clk);
         chk("R9 dvsync at next line", int'(dvsync), 1);
         chk("R9 field advanced", int'(field_id), k);
      end
      repeat (100) @(negedge clk);
      pulse(1, 1, 2);
      repeat (2) @(negedge clk);
      chk("R8 field 1 again", int'(field_id), 0);

      // constrained random traffic
      for (int it = 0; it < 250; it++) begin
         int act, per;
         per = 80 + ($urandom % 320);
         line_len_lo = per[7:0]; line_len_hi = per[10:8];
         burst_ofs = 8'($urandom % 60); video_ofs = 8'($urandom % 60);
         act = $urandom % 14;
         act_lines_lo = act[7:0];
         clamp_ofs = 8'($urandom % 120);
         dref_sel = ($urandom % 3) == 0;
         if ($urandom % 10 == 0) pal_mode = ~pal_mode;
         sync_src_sel = ($urandom % 6 == 0) ? 2'(1 + $urandom % 3) : 2'b00;
         repeat (20 + $urandom % 400) @(negedge clk);
         case ($urandom % 8)
            0, 1, 2, 3, 4: pulse(1, 0, 1 + $urandom % 6);
            5: pulse(1, 1, 1 + $urandom % 6);
            6: pulse(0, 1, 1 + $urandom % 6);
            default: ;
         endcase
      end
      repeat (50) @(negedge clk);
      cyc_on = 0;
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule